// File: doc/BRIEF.md
# Dual-Style Host Bus Front End for a Four-Channel Serial Controller

This block sits between a host processor bus and four serial channels. A strap input (`mode_sel`) picks one of two bus styles that share the same pins. With `mode_sel` high, each channel has its own active-low chip select, and separate active-low read and write strobes time the access. With `mode_sel` low, the first chip select is the only select and also times the access. The write-strobe pin then gives the direction, and the second and third chip-select pins become two channel address bits.

Each access is decoded into a channel number, a register index and a read or write. The byte moves through a split data bus: `din`, `dout` and `dout_oe`. Every bus input passes through a two-flop synchronizer before use.

The block also builds the device interrupt and ready pins from the per-channel signals. The channel datapaths are not part of this block. A stub of eight 8-bit registers per channel stands in for them. Index 4 of the stub plays the modem-control register, and its bit 3 enables that channel's interrupt pin.

Top module: `quad_uart_hostif`

## Requirements
- R1: After a synchronous reset, `dout_oe` is 0, every stub register reads back 0, and with `mode_sel` high every `irq_oe` bit is 0.
- R2: With `mode_sel` high and exactly one `cs_n[i]` low, a rising edge of `wr_n` stores `din` into register `addr` of channel i.
- R3: With `mode_sel` high and exactly one `cs_n[i]` low, a falling edge of `rd_n` drives register `addr` of channel i on `dout`, with `dout_oe` = 1. This holds until `rd_n` rises.
- R4: With `mode_sel` high and two or more chip selects low, strobes are ignored: no register changes and `dout_oe` stays 0.
- R5: With `mode_sel` low, `cs_n[0]` times the access and the channel is {`cs_n[2]`,`cs_n[1]`}. A falling `cs_n[0]` with `wr_n` = 1 starts a read, held until `cs_n[0]` rises. A rising `cs_n[0]` with `wr_n` = 0 performs a write.
- R6: With `mode_sel` low, `rd_n` and `cs_n[3]` have no effect.
- R7: With `mode_sel` high, `irq_o[i]` follows `chan_irq[i]` (active high), and `irq_oe[i]` equals bit 3 of register 4 of channel i.
- R8: With `mode_sel` low, `irq_o` is all 0, `irq_oe[3:1]` is 1, and `irq_oe[0]` is 1 exactly when any `chan_irq` bit is 1. This models an open-drain, active-low device interrupt.
- R9: `txrdy_n` is the AND of the four `chan_txrdy_n` bits, and `rxrdy_n` is the AND of the four `chan_rxrdy_n` bits.
- R10: A strobe edge takes effect on the third rising clock edge after the pin changes, and each edge produces exactly one internal write.
- R11: `dout_oe` is 0 whenever no read is in progress, including during writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 1 | Bus style: 1 = per-channel selects with separate strobes, 0 = single select with direction line |
| cs_n | input | 4 | Chip selects (style 1); in style 0: bit0 select, bit1/bit2 channel bits, bit3 unused |
| rd_n | input | 1 | Read strobe (style 1 only) |
| wr_n | input | 1 | Write strobe (style 1) or direction, 1 = read (style 0) |
| addr | input | AW | Register index |
| din | input | DW | Write data from the host |
| dout | output | DW | Read data to the host |
| dout_oe | output | 1 | Drive enable for the data bus |
| chan_irq | input | 4 | Per-channel pending interrupt, active high |
| chan_txrdy_n | input | 4 | Per-channel transmit ready, active low |
| chan_rxrdy_n | input | 4 | Per-channel receive ready, active low |
| irq_o | output | 4 | Interrupt pin values |
| irq_oe | output | 4 | Interrupt pin drive enables |
| txrdy_n | output | 1 | Combined transmit ready, active low |
| rxrdy_n | output | 1 | Combined receive ready, active low |

## Verification
Bus results land three rising edges after a pin transition: two edges for the synchronizer and one for the access register. The bench pins this down once by sampling `dout_oe` just after the second edge, where it must still be 0, and just after the third, where it must be 1. Every other access task waits four cycles after each transition before it samples or moves on. The interrupt and ready pins are combinational, so they are sampled a few nanoseconds after their inputs change. Sweeps write and read back all 32 registers in both bus styles, and a bench-side model of the registers predicts every read.

// File: rtl/hbi_pkg.sv
// Package: shared constants and helpers for the dual-style host bus front end.
// Assumes exactly four channels, because the pin reinterpretation is fixed at four.
package hbi_pkg;
    localparam int NCH = 4;
    localparam int CHW = $clog2(NCH);

    // Count how many active-low selects are asserted.
    function automatic int sel_count(input logic [NCH-1:0] sel_n);
        int n;
        n = 0;
        for (int i = 0; i < NCH; i++) begin
            if (!sel_n[i]) n++;
        end
        return n;
    endfunction
endpackage

// File: rtl/hbi_sync.sv
// Module: two-flop synchronizer for a vector of asynchronous bus pins.
// Assumes each bit is stable long enough to be sampled; no bus-coherence guarantee.
module hbi_sync #(
    parameter int W = 8,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two-stage capture into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/hbi_decode.sv
// Module: synchronizes the bus pins, detects strobe edges, and decodes each access
// into a channel, a register index and a read or write, in either bus style.
// Assumes mode_sel is a static strap, and that address and data are stable
// while a strobe is active.
module hbi_decode
    import hbi_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mode_sel,
    input  logic [NCH-1:0] cs_n,
    input  logic           rd_n,
    input  logic           wr_n,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  din,
    output logic           wr_pulse,
    output logic [CHW-1:0] wr_chan,
    output logic [AW-1:0]  wr_idx,
    output logic [DW-1:0]  wr_data,
    output logic           rd_act,
    output logic [CHW-1:0] rd_chan,
    output logic [AW-1:0]  rd_idx
);
    localparam int SW = NCH + 2 + AW + DW;

    logic [SW-1:0]  s_vec;
    logic [NCH-1:0] s_cs_n;
    logic           s_rd_n, s_wr_n;
    logic [AW-1:0]  s_addr;
    logic [DW-1:0]  s_din;
    logic           p_cs0, p_rd, p_wr;
    logic           one_sel;
    logic [CHW-1:0] chan_hi, chan;
    logic           rd_go, wr_go, rd_end;

    hbi_sync #(.W(SW), .RST_VAL('1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({cs_n, rd_n, wr_n, addr, din}),
        .q    (s_vec)
    );

    assign {s_cs_n, s_rd_n, s_wr_n, s_addr, s_din} = s_vec;

    // Remember the previous synchronized strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_cs0 <= 1'b1;
            p_rd  <= 1'b1;
            p_wr  <= 1'b1;
        end else begin
            p_cs0 <= s_cs_n[0];
            p_rd  <= s_rd_n;
            p_wr  <= s_wr_n;
        end
    end

    // Channel from the per-channel selects: index of the lowest active select.
    always_comb begin
        chan_hi = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (!s_cs_n[i]) chan_hi = CHW'(i);
        end
    end

    assign one_sel = (sel_count(s_cs_n) == 1);

    // Style-dependent start, end and channel decode.
    always_comb begin
        if (mode_sel) begin
            chan   = chan_hi;
            rd_go  = p_rd && !s_rd_n && one_sel;
            wr_go  = !p_wr && s_wr_n && one_sel;
            rd_end = (!p_rd && s_rd_n) || !one_sel;
        end else begin
            chan   = {s_cs_n[2], s_cs_n[1]};
            rd_go  = p_cs0 && !s_cs_n[0] && s_wr_n;
            wr_go  = !p_cs0 && s_cs_n[0] && !s_wr_n;
            rd_end = !p_cs0 && s_cs_n[0];
        end
    end

    // Write request register: one pulse per qualifying strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_pulse <= 1'b0;
            wr_chan  <= '0;
            wr_idx   <= '0;
            wr_data  <= '0;
        end else begin
            wr_pulse <= wr_go;
            wr_chan  <= chan;
            wr_idx   <= s_addr;
            wr_data  <= s_din;
        end
    end

    // Read-in-progress state with the channel and index captured at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_act  <= 1'b0;
            rd_chan <= '0;
            rd_idx  <= '0;
        end else if (rd_go) begin
            rd_act  <= 1'b1;
            rd_chan <= chan;
            rd_idx  <= s_addr;
        end else if (rd_end) begin
            rd_act  <= 1'b0;
        end
    end

    // R10
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

    // R4
    multi_sel_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel && sel_count(s_cs_n) > 1) |=> !rd_act);

    // R11
    rd_write_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_sel && !s_wr_n && p_cs0 && !s_cs_n[0]) |=> !$rose(rd_act));
endmodule

// File: rtl/hbi_regstub.sv
// Module: per-channel register stub that stands in for the channel datapaths.
// Each channel holds 2**AW registers of DW bits. Register MCR_IDX carries the
// interrupt-pin enable in bit IE_BIT.
module hbi_regstub
    import hbi_pkg::*;
#(
    parameter int DW      = 8,
    parameter int AW      = 3,
    parameter int MCR_IDX = 4,
    parameter int IE_BIT  = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [CHW-1:0] wr_chan,
    input  logic [AW-1:0]  wr_idx,
    input  logic [DW-1:0]  wr_data,
    input  logic [CHW-1:0] rd_chan,
    input  logic [AW-1:0]  rd_idx,
    output logic [DW-1:0]  rd_data,
    output logic [NCH-1:0] irq_en
);
    localparam int NREG = 1 << AW;

    logic [DW-1:0] regs [NCH][NREG];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // Register file of one channel, written on a matching request.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int k = 0; k < NREG; k++) regs[c][k] <= '0;
            end else if (wr_en && wr_chan == CHW'(c)) begin
                regs[c][wr_idx] <= wr_data;
            end
        end

        assign irq_en[c] = regs[c][MCR_IDX][IE_BIT];

        // R2
        reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_chan == CHW'(c)) |=> (regs[c][$past(wr_idx)] == $past(wr_data)));
    end

    assign rd_data = regs[rd_chan][rd_idx];
endmodule

// File: rtl/quad_uart_hostif.sv
// Module: top of the dual-style host bus front end. It ties the decoder to the
// register stub and forms the interrupt and combined ready pins.
// Assumes mode_sel is a strap that changes only while the bus is idle.
module quad_uart_hostif
    import hbi_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mode_sel,
    input  logic [3:0]     cs_n,
    input  logic           rd_n,
    input  logic           wr_n,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  din,
    output logic [DW-1:0]  dout,
    output logic           dout_oe,
    input  logic [3:0]     chan_irq,
    input  logic [3:0]     chan_txrdy_n,
    input  logic [3:0]     chan_rxrdy_n,
    output logic [3:0]     irq_o,
    output logic [3:0]     irq_oe,
    output logic           txrdy_n,
    output logic           rxrdy_n
);
    logic           wr_pulse, rd_act;
    logic [CHW-1:0] wr_chan, rd_chan;
    logic [AW-1:0]  wr_idx, rd_idx;
    logic [DW-1:0]  wr_data, rd_data;
    logic [NCH-1:0] irq_en;

    hbi_decode #(.DW(DW), .AW(AW)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_sel(mode_sel),
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .addr    (addr),
        .din     (din),
        .wr_pulse(wr_pulse),
        .wr_chan (wr_chan),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_act  (rd_act),
        .rd_chan (rd_chan),
        .rd_idx  (rd_idx)
    );

    hbi_regstub #(.DW(DW), .AW(AW), .MCR_IDX(4), .IE_BIT(3)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_pulse),
        .wr_chan(wr_chan),
        .wr_idx (wr_idx),
        .wr_data(wr_data),
        .rd_chan(rd_chan),
        .rd_idx (rd_idx),
        .rd_data(rd_data),
        .irq_en (irq_en)
    );

    assign dout    = rd_data;
    assign dout_oe = rd_act;

    // Interrupt pins: per-channel enabled outputs, or one wired-OR device line.
    always_comb begin
        if (mode_sel) begin
            irq_o  = chan_irq;
            irq_oe = irq_en;
        end else begin
            irq_o  = '0;
            irq_oe = {3'b111, |chan_irq};
        end
    end

    assign txrdy_n = &chan_txrdy_n;
    assign rxrdy_n = &chan_rxrdy_n;

    // R8
    dev_irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_sel && chan_irq != '0) |-> (irq_oe[0] && !irq_o[0]));

    // R9
    ready_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !txrdy_n |-> (chan_txrdy_n != 4'hF));
endmodule

// File: tb/quad_uart_hostif_tb.sv
module quad_uart_hostif_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode_sel;
    logic [3:0] cs_n;
    logic       rd_n, wr_n;
    logic [2:0] addr;
    logic [7:0] din;
    logic [7:0] dout;
    logic       dout_oe;
    logic [3:0] chan_irq, chan_txrdy_n, chan_rxrdy_n;
    logic [3:0] irq_o, irq_oe;
    logic       txrdy_n, rxrdy_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] model [4][8];

    always #10 clk = ~clk;

    quad_uart_hostif u_dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n),
        .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .din(din),
        .dout(dout), .dout_oe(dout_oe), .chan_irq(chan_irq),
        .chan_txrdy_n(chan_txrdy_n), .chan_rxrdy_n(chan_rxrdy_n),
        .irq_o(irq_o), .irq_oe(irq_oe), .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] pat(input int c, input int k, input int r);
        return 8'((c * 64 + k * 8 + r * 29 + 3) & 255);
    endfunction

    // Write in per-channel-select style.
    task automatic hi_write(input int c, input int k, input logic [7:0] v);
        cs_n = ~(4'b0001 << c); addr = 3'(k); din = v;
        cyc(4); wr_n = 1'b0; cyc(4); wr_n = 1'b1; cyc(4); cs_n = 4'hF; cyc(2);
        model[c][k] = v;
    endtask

    // Read in per-channel-select style and compare with the model.
    task automatic hi_read(input int c, input int k, input string tag);
        cs_n = ~(4'b0001 << c); addr = 3'(k);
        cyc(4); rd_n = 1'b0; cyc(4);
        chk(dout_oe === 1'b1, tag, dout_oe, 1);
        chk(dout === model[c][k], tag, dout, model[c][k]);
        rd_n = 1'b1; cyc(4);
        chk(dout_oe === 1'b0, tag, dout_oe, 0);
        cs_n = 4'hF; cyc(2);
    endtask

    // Access in single-select style; rw=1 read, 0 write. x3 drives the unused cs_n[3].
    task automatic lo_access(input int c, input int k, input bit rw, input logic [7:0] v,
                             input bit x3, input string tag);
        wr_n = rw; addr = 3'(k); din = v;
        cs_n = {x3, 1'(c >> 1), 1'(c & 1), 1'b1};
        cyc(4); cs_n[0] = 1'b0; cyc(4);
        if (rw) begin
            chk(dout_oe === 1'b1, tag, dout_oe, 1);
            chk(dout === model[c][k], tag, dout, model[c][k]);
        end else begin
            chk(dout_oe === 1'b0, tag, dout_oe, 0);
        end
        cs_n[0] = 1'b1; cyc(4);
        chk(dout_oe === 1'b0, tag, dout_oe, 0);
        wr_n = 1'b1; cs_n = 4'hF; cyc(2);
        if (!rw) model[c][k] = v;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; mode_sel = 1'b1; cs_n = 4'hF; rd_n = 1'b1; wr_n = 1'b1;
        addr = '0; din = '0; chan_irq = '0; chan_txrdy_n = 4'hF; chan_rxrdy_n = 4'hF;
        for (int c = 0; c < 4; c++) for (int k = 0; k < 8; k++) model[c][k] = '0;
        cyc(5); rst_n = 1'b1; cyc(2);

        // R1 reset state
        chk(dout_oe === 1'b0, "R1 oe", dout_oe, 0);
        chk(irq_oe === 4'h0, "R1 irq_oe", irq_oe, 0);
        for (int c = 0; c < 4; c++) for (int k = 0; k < 8; k++) hi_read(c, k, "R1 reg");

        // R10 latency: output enable appears on the third rising edge
        cs_n = 4'b1101; addr = 3'd0; cyc(4);
        rd_n = 1'b0;
        @(posedge clk); @(posedge clk); #2;
        chk(dout_oe === 1'b0, "R10 early", dout_oe, 0);
        @(posedge clk); #2;
        chk(dout_oe === 1'b1, "R10 due", dout_oe, 1);
        cyc(2); rd_n = 1'b1; cyc(4); cs_n = 4'hF; cyc(2);

        // R2 R3 R11 full sweep, per-channel-select style
        for (int c = 0; c < 4; c++) for (int k = 0; k < 8; k++) begin
            hi_write(c, k, pat(c, k, 1));
            chk(dout_oe === 1'b0, "R11 write", dout_oe, 0);
        end
        for (int c = 0; c < 4; c++) for (int k = 0; k < 8; k++) hi_read(c, k, "R2 R3 sweep");

        // R4 two selects low: write ignored, no drive on read
        cs_n = 4'b1100; addr = 3'd2; din = 8'hA5;
        cyc(4); wr_n = 1'b0; cyc(4); wr_n = 1'b1; cyc(4);
        rd_n = 1'b0; cyc(4);
        chk(dout_oe === 1'b0, "R4 no drive", dout_oe, 0);
        rd_n = 1'b1; cyc(4); cs_n = 4'hF; cyc(2);
        hi_read(0, 2, "R4 ch0 kept");
        hi_read(1, 2, "R4 ch1 kept");

        // R7 interrupt pins follow enables in register 4 bit 3
        for (int m = 0; m < 16; m++) begin
            for (int c = 0; c < 4; c++) hi_write(c, 4, ((m >> c) & 1) ? 8'h08 : 8'hF7);
            for (int p = 0; p < 16; p += 5) begin
                chan_irq = 4'(p); #3;
                chk(irq_oe === 4'(m), "R7 oe", irq_oe, m);
                chk(irq_o === 4'(p), "R7 val", irq_o, p);
            end
        end
        chan_irq = '0;

        // R9 ready combine, all patterns
        for (int t = 0; t < 16; t++) begin
            chan_txrdy_n = 4'(t); chan_rxrdy_n = 4'(15 - t); #3;
            chk(txrdy_n === (t == 15), "R9 tx", txrdy_n, (t == 15));
            chk(rxrdy_n === (t == 0), "R9 rx", rxrdy_n, (t == 0));
        end

        // R5 R6 single-select style sweep; rd_n held low, cs_n[3] varied
        mode_sel = 1'b0; cyc(4);
        rd_n = 1'b0; cyc(6);
        chk(dout_oe === 1'b0, "R6 rd_n ignored", dout_oe, 0);
        for (int c = 0; c < 4; c++) for (int k = 0; k < 8; k++)
            lo_access(c, k, 1'b0, pat(c, k, 2), 1'((c + k) & 1), "R5 write");
        for (int c = 0; c < 4; c++) for (int k = 0; k < 8; k++)
            lo_access(c, k, 1'b1, 8'h00, 1'((c + k + 1) & 1), "R5 R6 read");

        // R8 device interrupt line in single-select style
        for (int p = 0; p < 16; p++) begin
            chan_irq = 4'(p); #3;
            chk(irq_o === 4'h0, "R8 val", irq_o, 0);
            chk(irq_oe === {3'b111, (p != 0)}, "R8 oe", irq_oe, {3'b111, (p != 0)});
        end
        chan_irq = '0;

        // Cross-check: values written in one style read back in the other
        rd_n = 1'b1; mode_sel = 1'b1; cyc(4);
        for (int c = 0; c < 4; c++) hi_read(c, 7, "R5 cross");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule